// File: doc/BRIEF.md
# Narrow-to-Wide Word Packer

This block sits on the write side of a 36-bit word store. Writers may present data 9, 18 or 36 bits at a time on one 36-bit input bus, and the width in use is chosen at run time by a 2-bit select. The packer collects the narrow pieces into full 36-bit words and hands each finished word downstream with a one-cycle valid strobe.

Pieces fill the word from the low end. The first piece lands in the least-significant lane and each later piece goes one lane higher, until the word is full. The width select is sampled only on the first piece of a word. If the select moves while a word is still partly filled, the block keeps the width it started the word with. It finishes that word at the old width and raises a sticky error flag.

Top module: `word_packer`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `word_out` is zero, `word_valid` is low, `partial` is low and `mode_err` is low.
- R2: With `width_sel` = 0 (9-bit), only `din[8:0]` is taken. Four writes make one word, and write n (0 to 3) fills bits [9n+8:9n].
- R3: With `width_sel` = 1 (18-bit), only `din[17:0]` is taken. Two writes make one word: the first fills bits [17:0] and the second fills bits [35:18].
- R4: With `width_sel` = 3 (36-bit), every write is a complete word taken from all of `din`. Code 2 is treated the same as code 3.
- R5: `word_valid` is high for exactly the cycle after the write that completes a word, and `word_out` then shows that word. `word_out` holds its value until the next word completes.
- R6: A cycle with `wr_en` low changes nothing: the partial word, `partial` and `word_out` keep their values, and `word_valid` is low.
- R7: The select is applied on the first write of a word. A width change presented on that write takes effect immediately and does not set `mode_err`.
- R8: A write made while a word is partly filled, with a select that decodes to a different width, is handled at the word's original width and sets `mode_err`. `mode_err` stays set until reset.
- R9: `partial` is high exactly when some lanes of the current word hold data and the word is not yet complete.
- R10: Reset in the middle of a word discards the pieces already taken. The next write starts a new word in the lowest lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe: the piece on `din` is taken this cycle |
| width_sel | input | 2 | Width code: 0 = 9, 1 = 18, 2 or 3 = 36 bits |
| din | input | 36 | Write data; only the low active-width bits are used |
| word_out | output | 36 | Last completed word |
| word_valid | output | 1 | One-cycle strobe when `word_out` updates |
| partial | output | 1 | A word is partly assembled |
| mode_err | output | 1 | Sticky flag: the width select changed in the middle of a word |

## Verification
The checker assumes that `wr_en` and `width_sel` are stable and valid across each rising edge. It treats the select as meaningful only on writes, so it draws no conclusions from idle cycles. The bench drives every input on the falling edge and samples on the next falling edge. During idle cycles it leaves the select alone or changes it on purpose, and it fills the unused upper bits of `din` with junk, so the lane selection is tested.

// File: rtl/wp_pkg.sv
package wp_pkg;

    localparam int LANE_W    = 9;
    localparam int NUM_LANES = 4;
    localparam int WORD_W    = LANE_W * NUM_LANES;

    typedef enum logic [1:0] {
        WM_NARROW = 2'd0,
        WM_HALF   = 2'd1,
        WM_FULL   = 2'd2
    } wmode_e;

    // map the external 2-bit select onto an internal width mode
    function automatic wmode_e decode_sel(input logic [1:0] sel);
        case (sel)
            2'd0:    return WM_NARROW;
            2'd1:    return WM_HALF;
            default: return WM_FULL;
        endcase
    endfunction

    // number of lanes one write covers in a given mode
    function automatic int unsigned lanes_of(input wmode_e m, input int unsigned nl);
        case (m)
            WM_NARROW: return 1;
            WM_HALF:   return nl / 2;
            default:   return nl;
        endcase
    endfunction

endpackage

// File: rtl/wp_mode_ctl.sv
module wp_mode_ctl
    import wp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [1:0] width_sel,
    input  logic       at_boundary,
    output wmode_e     eff_mode,
    output logic       mode_err
);

    wmode_e held_mode;
    wmode_e req_mode;

    assign req_mode = decode_sel(width_sel);

    // a new width is only taken on the first piece of a word
    assign eff_mode = at_boundary ? req_mode : held_mode;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_mode <= WM_NARROW;
            mode_err  <= 1'b0;
        end else begin
            if (wr_en && at_boundary)
                held_mode <= req_mode;
            if (wr_en && !at_boundary && (req_mode != held_mode))
                mode_err <= 1'b1;
        end
    end

endmodule

// File: rtl/wp_lane_seq.sv
module wp_lane_seq
    import wp_pkg::*;
#(
    parameter int N_LANES = NUM_LANES,
    localparam int SLOT_W = $clog2(N_LANES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  wmode_e            eff_mode,
    output logic [SLOT_W-1:0] slot,
    output logic [SLOT_W:0]   step,
    output logic              last,
    output logic              at_boundary
);

    logic [SLOT_W:0] sum;

    assign step        = (SLOT_W+1)'(lanes_of(eff_mode, N_LANES));
    assign sum         = {1'b0, slot} + step;
    assign last        = (sum >= (SLOT_W+1)'(N_LANES));
    assign at_boundary = (slot == '0);

    always_ff @(posedge clk) begin
        if (rst)
            slot <= '0;
        else if (wr_en)
            slot <= last ? '0 : sum[SLOT_W-1:0];
    end

endmodule

// File: rtl/wp_assembler.sv
module wp_assembler
    import wp_pkg::*;
#(
    parameter int L_W     = LANE_W,
    parameter int N_LANES = NUM_LANES,
    localparam int SLOT_W = $clog2(N_LANES),
    localparam int W_W    = L_W * N_LANES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [W_W-1:0]    din,
    input  logic [SLOT_W-1:0] slot,
    input  logic [SLOT_W:0]   step,
    input  logic              last,
    output logic [W_W-1:0]    word_out,
    output logic              word_valid
);

    logic [L_W-1:0] acc    [N_LANES];
    logic [L_W-1:0] merged [N_LANES];
    logic [W_W-1:0] merged_flat;

    // each lane either keeps its stored piece or takes a slice of din
    for (genvar k = 0; k < N_LANES; k++) begin : g_lane
        logic [SLOT_W:0]   k_pos;
        logic              hit;
        logic [SLOT_W-1:0] src;
        assign k_pos = (SLOT_W+1)'(k);
        assign hit   = (k_pos >= {1'b0, slot}) && (k_pos < ({1'b0, slot} + step));
        assign src   = SLOT_W'(k) - slot;
        assign merged[k] = hit ? din[src*L_W +: L_W] : acc[k];
        assign merged_flat[k*L_W +: L_W] = merged[k];

        always_ff @(posedge clk) begin
            if (rst)
                acc[k] <= '0;
            else if (wr_en)
                acc[k] <= last ? '0 : merged[k];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word_out   <= '0;
            word_valid <= 1'b0;
        end else begin
            word_valid <= wr_en && last;
            if (wr_en && last)
                word_out <= merged_flat;
        end
    end

endmodule

// File: rtl/word_packer.sv
module word_packer
    import wp_pkg::*;
#(
    parameter int L_W     = LANE_W,
    parameter int N_LANES = NUM_LANES,
    localparam int SLOT_W = $clog2(N_LANES),
    localparam int W_W    = L_W * N_LANES
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           wr_en,
    input  logic [1:0]     width_sel,
    input  logic [W_W-1:0] din,
    output logic [W_W-1:0] word_out,
    output logic           word_valid,
    output logic           partial,
    output logic           mode_err
);

    wmode_e            eff_mode;
    logic [SLOT_W-1:0] slot;
    logic [SLOT_W:0]   step;
    logic              last;
    logic              at_boundary;

    wp_mode_ctl u_mode (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .width_sel   (width_sel),
        .at_boundary (at_boundary),
        .eff_mode    (eff_mode),
        .mode_err    (mode_err)
    );

    wp_lane_seq #(.N_LANES(N_LANES)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .eff_mode    (eff_mode),
        .slot        (slot),
        .step        (step),
        .last        (last),
        .at_boundary (at_boundary)
    );

    wp_assembler #(.L_W(L_W), .N_LANES(N_LANES)) u_asm (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .din        (din),
        .slot       (slot),
        .step       (step),
        .last       (last),
        .word_out   (word_out),
        .word_valid (word_valid)
    );

    assign partial = !at_boundary;

endmodule

// File: rtl/word_packer_chk.sv
module word_packer_chk #(
    parameter int W_W = 36
) (
    input logic           clk,
    input logic           rst,
    input logic           wr_en,
    input logic [1:0]     width_sel,
    input logic [W_W-1:0] word_out,
    input logic           word_valid,
    input logic           partial,
    input logic           mode_err
);

    // R5
    valid_after_write_chk: assert property (@(posedge clk) disable iff (rst)
        word_valid |-> $past(wr_en));

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> (!word_valid && $stable(word_out)));

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        mode_err |=> mode_err);

    // R9
    done_not_partial_chk: assert property (@(posedge clk) disable iff (rst)
        word_valid |-> !partial);

    // R4
    full_write_done_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !partial && width_sel[1]) |=> (word_valid && !partial));

    // R7
    boundary_no_err_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !partial && !mode_err) |=> !mode_err);

endmodule

bind word_packer word_packer_chk #(.W_W(W_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .width_sel  (width_sel),
    .word_out   (word_out),
    .word_valid (word_valid),
    .partial    (partial),
    .mode_err   (mode_err)
);

// File: tb/word_packer_bench.sv
module word_packer_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [1:0]  width_sel;
    logic [35:0] din;
    logic [35:0] word_out;
    logic        word_valid;
    logic        partial;
    logic        mode_err;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    word_packer u_word_packer (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .width_sel  (width_sel),
        .din        (din),
        .word_out   (word_out),
        .word_valid (word_valid),
        .partial    (partial),
        .mode_err   (mode_err)
    );

    task automatic chk(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_out(input string req, input logic [35:0] w, input bit v, input bit p, input bit e);
        chk(word_out == w, {req, " word_out"}, word_out, w);
        chk(word_valid == v, {req, " word_valid"}, 36'(word_valid), 36'(v));
        chk(partial == p, {req, " partial"}, 36'(partial), 36'(p));
        chk(mode_err == e, {req, " mode_err"}, 36'(mode_err), 36'(e));
    endtask

    // one write, then step to the following falling edge for sampling
    task automatic wr(input logic [1:0] sel, input logic [35:0] d);
        wr_en = 1'b1; width_sel = sel; din = d;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0; din = 36'hF_FFFF_FFFF;
    endtask

    task automatic idle(input logic [1:0] sel, input logic [35:0] d);
        wr_en = 1'b0; width_sel = sel; din = d;
        @(posedge clk); @(negedge clk);
    endtask

    task automatic do_reset;
        rst = 1'b1; wr_en = 1'b0; width_sel = 2'd0; din = '0;
        @(posedge clk); @(negedge clk);
        chk_out("R1 during", 36'h0, 1'b0, 1'b0, 1'b0);
        @(posedge clk); @(negedge clk);
        rst = 1'b0;
        @(posedge clk); @(negedge clk);
        chk_out("R1 after", 36'h0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_nine;
        wr(2'd0, {27'h7FF_FFFF, 9'h101});
        chk_out("R2 piece0", 36'h0, 1'b0, 1'b1, 1'b0);
        wr(2'd0, {27'h555_5555, 9'h0A2});
        chk_out("R9 piece1", 36'h0, 1'b0, 1'b1, 1'b0);
        wr(2'd0, {27'h2AA_AAAA, 9'h1C3});
        chk_out("R9 piece2", 36'h0, 1'b0, 1'b1, 1'b0);
        wr(2'd0, {27'h7FF_FFFF, 9'h044});
        chk_out("R2 word", {9'h044, 9'h1C3, 9'h0A2, 9'h101}, 1'b1, 1'b0, 1'b0);
        idle(2'd0, 36'h1_2345_6789);
        chk_out("R5 one-shot", {9'h044, 9'h1C3, 9'h0A2, 9'h101}, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_eighteen;
        wr(2'd1, {18'h3FFFF, 18'h2ABCD});
        chk_out("R3 half0", {9'h044, 9'h1C3, 9'h0A2, 9'h101}, 1'b0, 1'b1, 1'b0);
        wr(2'd1, {18'h0F0F0, 18'h15432});
        chk_out("R3 word", {18'h15432, 18'h2ABCD}, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_full;
        wr(2'd3, 36'h9_8765_4321);
        chk_out("R4 code3", 36'h9_8765_4321, 1'b1, 1'b0, 1'b0);
        wr(2'd2, 36'h1_2345_6789);
        chk_out("R4 code2", 36'h1_2345_6789, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_hold;
        wr(2'd0, {27'h0, 9'h011});
        for (int i = 0; i < 3; i++) begin
            idle(2'(i), 36'hA_BCDE_F012 + 36'(i));
            chk_out("R6 idle", 36'h1_2345_6789, 1'b0, 1'b1, 1'b0);
        end
        wr(2'd0, {27'h0, 9'h022});
        wr(2'd0, {27'h0, 9'h033});
        wr(2'd0, {27'h0, 9'h044});
        chk_out("R6 word", {9'h044, 9'h033, 9'h022, 9'h011}, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_switch;
        for (int i = 0; i < 4; i++) wr(2'd0, {27'h0, 9'(9'h0F0 + i)});
        chk_out("R7 narrow", {9'h0F3, 9'h0F2, 9'h0F1, 9'h0F0}, 1'b1, 1'b0, 1'b0);
        wr(2'd3, 36'hC_AFEF_00D5);
        chk_out("R7 to full", 36'hC_AFEF_00D5, 1'b1, 1'b0, 1'b0);
        wr(2'd1, 36'h0_0000_1234);
        chk_out("R7 to half", 36'hC_AFEF_00D5, 1'b0, 1'b1, 1'b0);
        wr(2'd1, 36'h0_0000_0567);
        chk_out("R7 half word", {18'h00567, 18'h01234}, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_midchange;
        wr(2'd0, {27'h1FF_FFFF, 9'h1A0});
        chk_out("R8 start", {18'h00567, 18'h01234}, 1'b0, 1'b1, 1'b0);
        wr(2'd3, {27'h7FF_FFFF, 9'h1A1});
        chk_out("R8 flagged", {18'h00567, 18'h01234}, 1'b0, 1'b1, 1'b1);
        wr(2'd1, {27'h7FF_FFFF, 9'h1A2});
        wr(2'd3, {27'h7FF_FFFF, 9'h1A3});
        chk_out("R8 deferred", {9'h1A3, 9'h1A2, 9'h1A1, 9'h1A0}, 1'b1, 1'b0, 1'b1);
        wr(2'd3, 36'h5_5555_AAAA);
        chk_out("R8 sticky", 36'h5_5555_AAAA, 1'b1, 1'b0, 1'b1);
    endtask

    task automatic t_reset_mid;
        do_reset();
        wr(2'd0, {27'h0, 9'h0EE});
        wr(2'd0, {27'h0, 9'h0DD});
        do_reset();
        for (int i = 0; i < 3; i++) wr(2'd0, {27'h0, 9'(9'h150 + i)});
        chk_out("R10 no early", 36'h0, 1'b0, 1'b1, 1'b0);
        wr(2'd0, {27'h0, 9'h153});
        chk_out("R10 fresh", {9'h153, 9'h152, 9'h151, 9'h150}, 1'b1, 1'b0, 1'b0);
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%h expected=%h", 36'h0, 36'h1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; width_sel = 2'd0; din = '0;
        @(negedge clk);
        do_reset();
        t_nine();
        t_eighteen();
        t_full();
        t_hold();
        t_switch();
        t_midchange();
        t_reset_mid();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule